// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Array

This block is one output cell of a programmable sum-of-products logic device. It takes the eight product terms that the AND array produces for this cell. Static configuration selects how the cell uses them. The cell can present a registered value, present a combinatorial value, act as a bidirectional combinatorial pin whose buffer is switched by one of its own product terms, or act as a plain input. The cell drives three outputs: a pin data value, a tri-state enable for the pad, and a feedback line that returns into the AND array.

Three selects choose the cell's mode. Two of them are shared by every cell in the device: `cfg_g0_i` says whether the device uses registers, and `cfg_g1_i` chooses between user-controlled and fixed buffers. The third, `cfg_mode_i`, is local to the cell. A fourth bit, `cfg_inv_i`, sets the output polarity. The flip-flop clears on reset, so a registered pin starts HIGH. A preload strobe can force the flip-flop to any pin level, so tests can reach a chosen state directly. When the cell is built as one of the two end cells of the device, a cell configured as a pure combinatorial output reuses its free feedback line to carry the level of the neighbouring shared pin.

Top module: `pal_macrocell`

## Requirements
- R1: Mode code {g0,g1,mode} = 010 is registered. At each rising clock edge the flip-flop takes (OR of all eight terms) XOR `cfg_inv_i`, and `pad_o` shows that value after the edge.
- R2: In registered mode, `pad_oe_o` equals `oe_pin_i`, and `fb_o` equals the registered output level.
- R3: Codes 011 and 111 are combinatorial I/O. `pad_o` = (OR of `pt_i[6:0]`) XOR `cfg_inv_i`, `pad_oe_o` = `pt_i[7]`, and `fb_o` = `pad_i`.
- R4: Code 100 is combinatorial output. `pad_o` = (OR of all eight terms) XOR `cfg_inv_i`, and `pad_oe_o` is 1. In an inner cell `fb_o` is 0.
- R5: Code 101 is dedicated input. `pad_oe_o` is 0 and `fb_o` = `pad_i`.
- R6: Codes 000, 001 and 110 are undefined. For these codes `pad_oe_o` is 0 and `fb_o` is 0.
- R7: When `cfg_inv_i` is 0 the sum reaches the pin unchanged (active high). When it is 1 the sum reaches the pin inverted (active low). This holds in the registered and combinatorial modes.
- R8: While `rst_ni` is low the flip-flop is cleared, and a registered cell drives `pad_o` = 1 for either polarity.
- R9: When `preload_i` is high at a rising edge, the registered pin level becomes `preload_data_i` and the sum for that edge is ignored.
- R10: An end cell (`EDGE_CELL`=1) in code 100 drives `fb_o` = `nbr_pad_i`. In every other mode an end cell behaves like an inner cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock; rising edge loads the flip-flop |
| rst_ni | input | 1 | Active-low power-up reset, asynchronous |
| pt_i | input | NUM_PT | Product terms from the AND array; top bit doubles as enable term |
| oe_pin_i | input | 1 | Global output-enable pin, active high |
| pad_i | input | 1 | Level sensed on this cell's pin |
| nbr_pad_i | input | 1 | Level of the adjacent shared pin (used by end cells) |
| cfg_g0_i | input | 1 | Global select: 0 = device has registers |
| cfg_g1_i | input | 1 | Global select: buffer control style |
| cfg_mode_i | input | 1 | Local mode select |
| cfg_inv_i | input | 1 | Local polarity select: 1 = active low |
| preload_i | input | 1 | Synchronous preload strobe |
| preload_data_i | input | 1 | Pin level to preload |
| pad_o | output | 1 | Data driven toward the pin |
| pad_oe_o | output | 1 | Tri-state enable for the pin |
| fb_o | output | 1 | Feedback into the AND array |

## Verification
The bound checker looks at every cycle and enforces the enable and feedback routing of each mode. It also checks that the combinatorial output equals the polarity-adjusted sum, that the registered pin shows the sum or the preload value from the previous edge, and that reset holds a registered pin HIGH. Some behaviour can only be shown by the bench's scenarios. These are the exclusion of the top term from the sum in the I/O modes, the use of the neighbouring pin by the end-cell variant while the inner cell ignores it, and return to normal capture after a preload.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;

   typedef enum logic [2:0] {
      MC_REG,
      MC_CIO_REGDEV,
      MC_COMB_OUT,
      MC_DED_IN,
      MC_CIO_COMBDEV,
      MC_ILLEGAL
   } mc_mode_e;

   typedef enum logic [1:0] {
      EN_PIN,
      EN_TERM,
      EN_ON,
      EN_OFF
   } en_src_e;

   typedef enum logic [1:0] {
      FB_REG,
      FB_PAD,
      FB_ADJ,
      FB_ZERO
   } fb_src_e;

   typedef struct packed {
      mc_mode_e mode;
      en_src_e  en_src;
      fb_src_e  fb_src;
      logic     drop_term;
      logic     use_reg;
   } mc_ctrl_t;

   function automatic mc_mode_e decode_mode(input logic g0, input logic g1, input logic l0);
      mc_mode_e m;
      unique case ({g0, g1, l0})
         3'b010:  m = MC_REG;
         3'b011:  m = MC_CIO_REGDEV;
         3'b100:  m = MC_COMB_OUT;
         3'b101:  m = MC_DED_IN;
         3'b111:  m = MC_CIO_COMBDEV;
         default: m = MC_ILLEGAL;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/pal_mc_decode.sv
module pal_mc_decode
   import pal_mc_pkg::*;
#(
   parameter bit EDGE_CELL = 1'b0
) (
   input  logic     g0_i,
   input  logic     g1_i,
   input  logic     mode_i,
   output mc_ctrl_t ctrl_o
);

   mc_mode_e mode;
   fb_src_e  comb_out_fb;

   assign mode = decode_mode(g0_i, g1_i, mode_i);

   generate
      if (EDGE_CELL) begin : g_edge_fb
         assign comb_out_fb = FB_ADJ;
      end else begin : g_inner_fb
         assign comb_out_fb = FB_ZERO;
      end
   endgenerate

   always_comb begin
      ctrl_o.mode      = mode;
      ctrl_o.en_src    = EN_OFF;
      ctrl_o.fb_src    = FB_ZERO;
      ctrl_o.drop_term = 1'b0;
      ctrl_o.use_reg   = 1'b0;
      unique case (mode)
         MC_REG: begin
            ctrl_o.en_src  = EN_PIN;
            ctrl_o.fb_src  = FB_REG;
            ctrl_o.use_reg = 1'b1;
         end
         MC_CIO_REGDEV, MC_CIO_COMBDEV: begin
            ctrl_o.en_src    = EN_TERM;
            ctrl_o.fb_src    = FB_PAD;
            ctrl_o.drop_term = 1'b1;
         end
         MC_COMB_OUT: begin
            ctrl_o.en_src = EN_ON;
            ctrl_o.fb_src = comb_out_fb;
         end
         MC_DED_IN: begin
            ctrl_o.en_src = EN_OFF;
            ctrl_o.fb_src = FB_PAD;
         end
         default: begin
            ctrl_o.en_src = EN_OFF;
            ctrl_o.fb_src = FB_ZERO;
         end
      endcase
   end

endmodule

// File: rtl/pal_mc_sum.sv
module pal_mc_sum #(
   parameter int NUM_PT = 8
) (
   input  logic [NUM_PT-1:0] pt_i,
   input  logic              drop_term_i,
   output logic              sum_o,
   output logic              en_term_o
);

   localparam int EN_IDX   = NUM_PT - 1;
   localparam int TRUNK_W  = NUM_PT - 1;

   logic [TRUNK_W-1:0] trunk_or;

   generate
      for (genvar i = 0; i < TRUNK_W; i++) begin : g_trunk
         if (i == 0) begin : g_first
            assign trunk_or[i] = pt_i[i];
         end else begin : g_chain
            assign trunk_or[i] = trunk_or[i-1] | pt_i[i];
         end
      end
   endgenerate

   assign en_term_o = pt_i[EN_IDX];
   assign sum_o     = drop_term_i ? trunk_or[TRUNK_W-1]
                                  : (trunk_or[TRUNK_W-1] | pt_i[EN_IDX]);

endmodule

// File: rtl/pal_mc_reg.sv
module pal_mc_reg (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   input  logic load_i,
   input  logic load_lvl_i,
   output logic lvl_o
);

   logic q_r;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q_r <= 1'b0;
      end else if (load_i) begin
         q_r <= ~load_lvl_i;
      end else begin
         q_r <= ~lvl_i;
      end
   end

   assign lvl_o = ~q_r;

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
   import pal_mc_pkg::*;
#(
   parameter int NUM_PT    = 8,
   parameter bit EDGE_CELL = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_PT-1:0] pt_i,
   input  logic              oe_pin_i,
   input  logic              pad_i,
   input  logic              nbr_pad_i,
   input  logic              cfg_g0_i,
   input  logic              cfg_g1_i,
   input  logic              cfg_mode_i,
   input  logic              cfg_inv_i,
   input  logic              preload_i,
   input  logic              preload_data_i,
   output logic              pad_o,
   output logic              pad_oe_o,
   output logic              fb_o
);

   generate
      if (NUM_PT < 2) begin : g_bad_width
         $error("pal_macrocell: NUM_PT must be at least 2");
      end
   endgenerate

   mc_ctrl_t ctrl;
   logic     sum;
   logic     en_term;
   logic     comb_lvl;
   logic     reg_lvl;

   pal_mc_decode #(
      .EDGE_CELL (EDGE_CELL)
   ) u_decode (
      .g0_i   (cfg_g0_i),
      .g1_i   (cfg_g1_i),
      .mode_i (cfg_mode_i),
      .ctrl_o (ctrl)
   );

   pal_mc_sum #(
      .NUM_PT (NUM_PT)
   ) u_sum (
      .pt_i        (pt_i),
      .drop_term_i (ctrl.drop_term),
      .sum_o       (sum),
      .en_term_o   (en_term)
   );

   assign comb_lvl = sum ^ cfg_inv_i;

   pal_mc_reg u_reg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lvl_i      (comb_lvl),
      .load_i     (preload_i),
      .load_lvl_i (preload_data_i),
      .lvl_o      (reg_lvl)
   );

   assign pad_o = ctrl.use_reg ? reg_lvl : comb_lvl;

   always_comb begin
      unique case (ctrl.en_src)
         EN_PIN:  pad_oe_o = oe_pin_i;
         EN_TERM: pad_oe_o = en_term;
         EN_ON:   pad_oe_o = 1'b1;
         default: pad_oe_o = 1'b0;
      endcase
   end

   always_comb begin
      unique case (ctrl.fb_src)
         FB_REG:  fb_o = reg_lvl;
         FB_PAD:  fb_o = pad_i;
         FB_ADJ:  fb_o = nbr_pad_i;
         default: fb_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk #(
   parameter int NUM_PT    = 8,
   parameter bit EDGE_CELL = 1'b0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [NUM_PT-1:0] pt_i,
   input logic              oe_pin_i,
   input logic              pad_i,
   input logic              nbr_pad_i,
   input logic              cfg_g0_i,
   input logic              cfg_g1_i,
   input logic              cfg_mode_i,
   input logic              cfg_inv_i,
   input logic              preload_i,
   input logic              preload_data_i,
   input logic              pad_o,
   input logic              pad_oe_o,
   input logic              fb_o
);

   logic [2:0] code;
   logic       is_reg, is_cio, is_comb, is_din, is_bad;
   logic       armed;

   assign code    = {cfg_g0_i, cfg_g1_i, cfg_mode_i};
   assign is_reg  = (code == 3'b010);
   assign is_cio  = (code == 3'b011) || (code == 3'b111);
   assign is_comb = (code == 3'b100);
   assign is_din  = (code == 3'b101);
   assign is_bad  = (code == 3'b000) || (code == 3'b001) || (code == 3'b110);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed <= 1'b0;
      else         armed <= 1'b1;
   end

   // R1
   a_r1_reg_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && is_reg && $past(is_reg) && !$past(preload_i))
         |-> pad_o == ($past(|pt_i) ^ $past(cfg_inv_i)));

   // R2
   a_r2_reg_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_reg |-> (pad_oe_o == oe_pin_i) && (fb_o == pad_o));

   // R3
   a_r3_cio_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_cio |-> (pad_oe_o == pt_i[NUM_PT-1]) && (fb_o == pad_i));

   // R4 and R7
   a_r4_comb_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_comb |-> pad_oe_o && (pad_o == ((|pt_i) ^ cfg_inv_i)));

   // R5
   a_r5_ded_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_din |-> !pad_oe_o && (fb_o == pad_i));

   // R6
   a_r6_undefined_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_bad |-> !pad_oe_o && !fb_o);

   // R9
   a_r9_preload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && is_reg && $past(preload_i)) |-> pad_o == $past(preload_data_i));

   // R8
   always @(negedge clk_i) begin
      if (!rst_ni && is_reg) begin
         a_r8_reset_high: assert (pad_o == 1'b1);
      end
   end

endmodule

bind pal_macrocell pal_macrocell_chk #(
   .NUM_PT    (NUM_PT),
   .EDGE_CELL (EDGE_CELL)
) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .pt_i           (pt_i),
   .oe_pin_i       (oe_pin_i),
   .pad_i          (pad_i),
   .nbr_pad_i      (nbr_pad_i),
   .cfg_g0_i       (cfg_g0_i),
   .cfg_g1_i       (cfg_g1_i),
   .cfg_mode_i     (cfg_mode_i),
   .cfg_inv_i      (cfg_inv_i),
   .preload_i      (preload_i),
   .preload_data_i (preload_data_i),
   .pad_o          (pad_o),
   .pad_oe_o       (pad_oe_o),
   .fb_o           (fb_o)
);

// File: tb/pal_macrocell_tb.sv
module pal_macrocell_tb;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic [7:0] pt_i = '0;
   logic       oe_pin_i = 1'b1;
   logic       pad_i = 1'b0;
   logic       nbr_pad_i = 1'b0;
   logic       cfg_g0_i = 1'b0;
   logic       cfg_g1_i = 1'b1;
   logic       cfg_mode_i = 1'b0;
   logic       cfg_inv_i = 1'b0;
   logic       preload_i = 1'b0;
   logic       preload_data_i = 1'b0;
   logic       pad_o, pad_oe_o, fb_o;
   logic       e_pad_o, e_pad_oe_o, e_fb_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2 clk_i = ~clk_i;

   pal_macrocell #(.NUM_PT(8), .EDGE_CELL(1'b0)) u_dut (
      .clk_i, .rst_ni, .pt_i, .oe_pin_i, .pad_i, .nbr_pad_i,
      .cfg_g0_i, .cfg_g1_i, .cfg_mode_i, .cfg_inv_i,
      .preload_i, .preload_data_i, .pad_o, .pad_oe_o, .fb_o);

   pal_macrocell #(.NUM_PT(8), .EDGE_CELL(1'b1)) u_end (
      .clk_i, .rst_ni, .pt_i, .oe_pin_i, .pad_i, .nbr_pad_i,
      .cfg_g0_i, .cfg_g1_i, .cfg_mode_i, .cfg_inv_i,
      .preload_i, .preload_data_i,
      .pad_o(e_pad_o), .pad_oe_o(e_pad_oe_o), .fb_o(e_fb_o));

   task automatic chk(input string req, input string what, input logic got, input logic exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
      end
   endtask

   task automatic set_code(input logic [2:0] c);
      {cfg_g0_i, cfg_g1_i, cfg_mode_i} = c;
   endtask

   task automatic t_reset;
      set_code(3'b010);
      cfg_inv_i = 1'b0;
      pt_i = 8'hFF;
      #1;
      chk("R8", "reset pad inv0", pad_o, 1'b1);
      chk("R2", "reset fb level", fb_o, 1'b1);
      cfg_inv_i = 1'b1;
      #1;
      chk("R8", "reset pad inv1", pad_o, 1'b1);
      @(negedge clk_i);
      rst_ni = 1'b1;
   endtask

   task automatic t_registered;
      @(negedge clk_i);
      set_code(3'b010); cfg_inv_i = 1'b0; pt_i = 8'h00; oe_pin_i = 1'b1;
      @(posedge clk_i); #1;
      chk("R1", "reg sum zero", pad_o, 1'b0);
      @(negedge clk_i); pt_i = 8'h80;
      #1;
      chk("R1", "reg holds before edge", pad_o, 1'b0);
      @(posedge clk_i); #1;
      chk("R1", "reg top term", pad_o, 1'b1);
      chk("R2", "reg fb level", fb_o, 1'b1);
      chk("R2", "reg oe pin high", pad_oe_o, 1'b1);
      @(negedge clk_i); oe_pin_i = 1'b0;
      #1;
      chk("R2", "reg oe pin low", pad_oe_o, 1'b0);
      cfg_inv_i = 1'b1;
      @(posedge clk_i); #1;
      chk("R7", "reg active low", pad_o, 1'b0);
      chk("R2", "reg fb inverted level", fb_o, 1'b0);
      oe_pin_i = 1'b1;
   endtask

   task automatic t_preload;
      @(negedge clk_i);
      set_code(3'b010); cfg_inv_i = 1'b0; pt_i = 8'h00;
      preload_i = 1'b1; preload_data_i = 1'b1;
      @(posedge clk_i); #1;
      chk("R9", "preload one over zero sum", pad_o, 1'b1);
      @(negedge clk_i); preload_i = 1'b0;
      @(posedge clk_i); #1;
      chk("R9", "capture resumes", pad_o, 1'b0);
      @(negedge clk_i); pt_i = 8'h04; preload_i = 1'b1; preload_data_i = 1'b0;
      @(posedge clk_i); #1;
      chk("R9", "preload zero over one sum", pad_o, 1'b0);
      @(negedge clk_i); preload_i = 1'b0;
   endtask

   task automatic t_comb_io;
      for (int k = 0; k < 2; k++) begin
         @(negedge clk_i);
         set_code(k == 0 ? 3'b011 : 3'b111);
         cfg_inv_i = 1'b0; pt_i = 8'h80; pad_i = 1'b1;
         #1;
         chk("R3", "top term excluded from sum", pad_o, 1'b0);
         chk("R3", "top term enables", pad_oe_o, 1'b1);
         chk("R3", "fb from pad", fb_o, 1'b1);
         pt_i = 8'h01; pad_i = 1'b0;
         #1;
         chk("R3", "low term in sum", pad_o, 1'b1);
         chk("R3", "buffer off", pad_oe_o, 1'b0);
         chk("R3", "fb pad low", fb_o, 1'b0);
      end
   endtask

   task automatic t_comb_out;
      @(negedge clk_i);
      set_code(3'b100); cfg_inv_i = 1'b0; pt_i = 8'h80; nbr_pad_i = 1'b1;
      #1;
      chk("R4", "comb all terms", pad_o, 1'b1);
      chk("R4", "comb always on", pad_oe_o, 1'b1);
      chk("R4", "inner fb unused", fb_o, 1'b0);
      chk("R10", "end fb from neighbour", e_fb_o, 1'b1);
      cfg_inv_i = 1'b1;
      #1;
      chk("R7", "comb active low", pad_o, 1'b0);
      nbr_pad_i = 1'b0; pt_i = 8'h00;
      #1;
      chk("R7", "comb active low idle", pad_o, 1'b1);
      chk("R10", "end fb neighbour low", e_fb_o, 1'b0);
      cfg_inv_i = 1'b0;
   endtask

   task automatic t_ded_input;
      @(negedge clk_i);
      set_code(3'b101); pt_i = 8'hFF; pad_i = 1'b1; nbr_pad_i = 1'b0;
      #1;
      chk("R5", "input buffer off", pad_oe_o, 1'b0);
      chk("R5", "input fb high", fb_o, 1'b1);
      chk("R10", "end cell input fb pad", e_fb_o, 1'b1);
      pad_i = 1'b0;
      #1;
      chk("R5", "input fb low", fb_o, 1'b0);
   endtask

   task automatic t_undefined;
      logic [2:0] codes [3];
      codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b110;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk_i);
         set_code(codes[k]); pt_i = 8'hFF; pad_i = 1'b1; nbr_pad_i = 1'b1;
         #1;
         chk("R6", "undefined buffer off", pad_oe_o, 1'b0);
         chk("R6", "undefined fb zero", fb_o, 1'b0);
         chk("R6", "undefined end fb zero", e_fb_o, 1'b0);
      end
   endtask

   initial begin
      #40000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      t_reset;
      t_registered;
      t_preload;
      t_comb_io;
      t_comb_out;
      t_ded_input;
      t_undefined;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule